// File: doc/BRIEF.md
# Cascadable Converter Serial Output Stage

This block is the serial readout logic of one data converter that can sit in a cascade of identical converters sharing one data line. At each conversion boundary it captures a 24-bit result into a shift register and signals availability by pulling an active-low ready flag down. The host then clocks the word out, most significant bit first, with falling edges of a serial clock. The bit present on the serial input is shifted into the bottom of the register on every such edge. Once a device's own word has left, the results of the devices behind it follow on its output, so the first device in the cascade presents every result in turn on one wire.

A common sync pulse clears the register and restarts a settling window. The window lasts a programmable number of conversion periods, and during it no result is captured and the ready flag stays high. Serial clock, serial input and chip select are oversampled on the system clock, so the serial clock must run well below the system clock. The sequencer has three states. SETTLE waits out the window. LOADED is the one-cycle state right after a capture, in which the flag is high. READY holds the flag low. The transitions are: sync from any state goes to SETTLE. A strobe in SETTLE at the last window count goes to LOADED. A strobe in READY goes to LOADED. LOADED goes to READY unless a further strobe arrives, in which case it stays in LOADED. A strobe in SETTLE before the last count only advances the window counter.

Top module: `daisy_out_stage`

## Requirements
- R1: While reset is held, and right after it is released, drdy_n is 1, sdo is 0, and sdo_oe is 0 while cs_n is 1.
- R2: After a sync pulse or after reset, the first SETTLE_PERIODS strobes (default 3) are discarded: no capture takes place and drdy_n stays 1. The next strobe captures conv_word.
- R3: Once a word is captured, sdo presents bit 23 before any serial clock edge. After the k-th falling sclk edge (k below 24), sdo presents bit 23-k.
- R4: A rising sclk edge never changes sdo.
- R5: On each falling sclk edge the level of sdi is captured. After the 24 local bits, sdo presents the captured sdi bits in arrival order, delayed by exactly 24 falling edges.
- R6: With sdi held at 0, sdo is 0 after the local word has been shifted out.
- R7: sdo_oe equals the inverse of cs_n. While cs_n is 1, falling sclk edges do not shift the register, and readout resumes at the same bit when cs_n returns to 0.
- R8: A strobe while drdy_n is 0 captures the new word even if the old one was only partly read. drdy_n is 1 in the cycle after that strobe.
- R9: A sync pulse forces drdy_n to 1 and sdo to 0 in the following cycle, and it restarts the settling window of R2.
- R10: After every capture, drdy_n is 1 for exactly one system clock cycle before it falls, unless another strobe or a sync arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_word | input | 24 | Conversion result to capture |
| conv_strobe | input | 1 | One-cycle conversion boundary pulse |
| sync_req | input | 1 | Synchronous sync pulse: clears the register and restarts the settling window |
| sclk | input | 1 | Serial clock, idles high; data advances on its falling edge |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial input from the next device in the cascade (tied to 0 on the last device) |
| sdo | output | 1 | Serial output, MSB first |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| drdy_n | output | 1 | Data-ready flag, active low |

## Verification
The readout is driven with sdi carrying a distinct downstream word and then held at 0. This separates correct forwarding with a 24-edge delay from zero fill or an off-by-one delay. Every falling edge is followed by a rising edge, and the bench checks after each one, so shifting on the wrong edge is caught. Reads are also tried with chip select lifted in mid-word, with a new strobe arriving after only a few bits, and with a sync in mid-frame. These show that chip select gating, capture priority over a partial read and the restarted settling count each behave as required.

// File: rtl/daisy_out_pkg.sv
package daisy_out_pkg;

    // Sequencer states of the readout stage
    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,   // waiting out the post-sync window
        ST_LOADED = 2'd1,   // word captured, ready flag still high
        ST_READY  = 2'd2    // ready flag low, host may read
    } seq_state_t;

endpackage

// File: rtl/dos_input_sync.sv
// Oversamples the serial-side inputs on the system clock and flags falling
// edges of the serial clock. sdi and cs_n pass through the same number of
// stages, so they stay aligned with the detected edge.
module dos_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    input  logic cs_n,
    output logic sclk_fall,
    output logic sdi_smp,
    output logic cs_active
);
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] sdi_pipe;
    logic [STAGES-1:0] cs_pipe;
    logic              sclk_last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_pipe <= '1;
                    sdi_pipe  <= '0;
                    cs_pipe   <= '1;
                end else begin
                    sclk_pipe <= sclk;
                    sdi_pipe  <= sdi;
                    cs_pipe   <= cs_n;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_pipe <= '1;
                    sdi_pipe  <= '0;
                    cs_pipe   <= '1;
                end else begin
                    sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
                    sdi_pipe  <= {sdi_pipe[STAGES-2:0], sdi};
                    cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_last <= 1'b1;
        end else begin
            sclk_last <= sclk_pipe[STAGES-1];
        end
    end

    assign sclk_fall = sclk_last & ~sclk_pipe[STAGES-1];
    assign sdi_smp   = sdi_pipe[STAGES-1];
    assign cs_active = ~cs_pipe[STAGES-1];

endmodule

// File: rtl/dos_sequencer.sv
// Settling window and ready-flag state machine.
module dos_sequencer
    import daisy_out_pkg::*;
#(
    parameter int SETTLE_PERIODS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_strobe,
    input  logic sync_req,
    output logic load_en,
    output logic clear_en,
    output logic drdy_n
);
    localparam int CNT_W = (SETTLE_PERIODS > 0) ? $clog2(SETTLE_PERIODS + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_PERIODS);

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             window_done;

    assign window_done = (cnt == CNT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SETTLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (sync_req) begin
            state_nx = ST_SETTLE;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_SETTLE: begin
                    if (conv_strobe) begin
                        if (window_done) begin
                            state_nx = ST_LOADED;
                        end else begin
                            cnt_nx = cnt + 1'b1;
                        end
                    end
                end
                ST_LOADED: begin
                    state_nx = conv_strobe ? ST_LOADED : ST_READY;
                end
                ST_READY: begin
                    if (conv_strobe) begin
                        state_nx = ST_LOADED;
                    end
                end
                default: begin
                    state_nx = ST_SETTLE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        clear_en = sync_req;
        load_en  = 1'b0;
        drdy_n   = 1'b1;
        unique case (state)
            ST_SETTLE: load_en = conv_strobe & window_done & ~sync_req;
            ST_LOADED: load_en = conv_strobe & ~sync_req;
            ST_READY: begin
                load_en = conv_strobe & ~sync_req;
                drdy_n  = 1'b0;
            end
            default: load_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/dos_shifter.sv
// Output shift register: parallel capture, serial shift with fill from sdi.
module dos_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_en,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] word,
    input  logic              fill_bit,
    output logic              msb
);
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (clear_en) begin
            shreg <= '0;
        end else if (load_en) begin
            shreg <= word;
        end else if (shift_en) begin
            shreg <= {shreg[WORD_W-2:0], fill_bit};
        end
    end

    assign msb = shreg[WORD_W-1];

endmodule

// File: rtl/daisy_out_stage.sv
// Top of the cascadable serial output stage.
module daisy_out_stage #(
    parameter int WORD_W         = 24,
    parameter int SETTLE_PERIODS = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] conv_word,
    input  logic              conv_strobe,
    input  logic              sync_req,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              drdy_n
);
    logic sclk_fall;
    logic sdi_smp;
    logic cs_active;
    logic load_en;
    logic clear_en;
    logic shift_en;

    dos_input_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .cs_n     (cs_n),
        .sclk_fall(sclk_fall),
        .sdi_smp  (sdi_smp),
        .cs_active(cs_active)
    );

    dos_sequencer #(
        .SETTLE_PERIODS(SETTLE_PERIODS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_strobe(conv_strobe),
        .sync_req   (sync_req),
        .load_en    (load_en),
        .clear_en   (clear_en),
        .drdy_n     (drdy_n)
    );

    assign shift_en = sclk_fall & cs_active;

    dos_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_en(clear_en),
        .load_en (load_en),
        .shift_en(shift_en),
        .word    (conv_word),
        .fill_bit(sdi_smp),
        .msb     (sdo)
    );

    assign sdo_oe = ~cs_n;

endmodule

// File: rtl/daisy_out_stage_chk.sv
// Temporal checks on the output stage, attached by bind.
module daisy_out_stage_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_strobe,
    input logic sync_req,
    input logic cs_n,
    input logic sdo,
    input logic drdy_n
);
    // R7: with chip select high for long enough, sdo only moves on capture or sync
    a_r7_hold_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && !conv_strobe && !sync_req)
        |=> (conv_strobe || sync_req || $stable(sdo)));

    // R8: a strobe while ready raises the flag in the next cycle
    a_r8_strobe_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && conv_strobe && !sync_req) |=> drdy_n);

    // R9: sync clears the output and raises the flag
    a_r9_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (drdy_n && !sdo));

    // R10: flag high for one cycle after a capture, then low
    a_r10_one_cycle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drdy_n) && !$past(sync_req) && !sync_req && !conv_strobe) |=> !drdy_n);

endmodule

bind daisy_out_stage daisy_out_stage_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_strobe(conv_strobe),
    .sync_req   (sync_req),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .drdy_n     (drdy_n)
);

// File: tb/daisy_out_stage_test.sv
`timescale 1ns/1ps
module daisy_out_stage_test;
    localparam int W  = 24;
    localparam int SP = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] conv_word = '0;
    logic         conv_strobe = 1'b0;
    logic         sync_req = 1'b0;
    logic         sclk = 1'b1;
    logic         cs_n = 1'b1;
    logic         sdi = 1'b0;
    logic         sdo, sdo_oe, drdy_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    daisy_out_stage #(.WORD_W(W), .SETTLE_PERIODS(SP)) uut (
        .clk(clk), .rst_n(rst_n), .conv_word(conv_word), .conv_strobe(conv_strobe),
        .sync_req(sync_req), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .drdy_n(drdy_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_word(input logic [W-1:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) exp_q.push_back(w[i]);
    endtask

    // Driver: one conversion strobe; checks the capture and the flag gap
    task automatic strobe(input logic [W-1:0] w, input bit expect_load, input string req);
        @(negedge clk);
        conv_word   = w;
        conv_strobe = 1'b1;
        @(negedge clk);
        conv_strobe = 1'b0;
        if (expect_load) begin
            check(sdo == w[W-1], req, sdo, w[W-1]);
            check(drdy_n == 1'b1, "R10 gap high", drdy_n, 1);
            @(negedge clk);
            check(drdy_n == 1'b0, "R10 flag low after gap", drdy_n, 0);
        end else begin
            check(drdy_n == 1'b1, "R2 flag high in window", drdy_n, 1);
            check(sdo == 1'b0, "R2 no capture in window", sdo, 0);
        end
    endtask

    // Serial clock period; monitor pops the expected bit when a shift is due
    task automatic sclk_cycle(input logic din, input bit expect_shift, input string req);
        logic prev;
        prev = sdo;
        sdi = din;
        repeat (3) @(posedge clk);
        sclk = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        if (expect_shift) begin
            bit e;
            e = exp_q.pop_front();
            check(sdo == e, req, sdo, e);
        end else begin
            check(sdo == prev, "R7 no shift while deselected", sdo, prev);
        end
        prev = sdo;
        sclk = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(sdo == prev, "R4 rising edge holds sdo", sdo, prev);
    endtask

    task automatic do_sync();
        @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        check(drdy_n == 1'b1, "R9 flag high after sync", drdy_n, 1);
        check(sdo == 1'b0, "R9 sdo cleared by sync", sdo, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [W-1:0] w1, d1, w2, w3, w4;
        w1 = 24'hA5C3F1;
        d1 = 24'h9B2E67;
        w2 = 24'hC0FFEE;
        w3 = 24'h812345;
        w4 = 24'hF0F00F;

        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(drdy_n == 1'b1, "R1 flag in reset", drdy_n, 1);
        check(sdo == 1'b0, "R1 sdo in reset", sdo, 0);
        check(sdo_oe == 1'b0, "R1 oe off", sdo_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(drdy_n == 1'b1, "R1 flag after reset", drdy_n, 1);

        // R2: settling window after reset
        for (int i = 0; i < SP; i++) strobe(24'hFFFFFF, 1'b0, "R2");
        cs_n = 1'b0;
        strobe(w1, 1'b1, "R3 MSB presented after capture");
        check(sdo_oe == 1'b1, "R7 oe on when selected", sdo_oe, 1);

        // R3/R5/R6: local word, then downstream word, then zero fill
        exp_q.delete();
        push_word(w1, W - 1);
        push_word(d1, W);
        push_word('0, 4);
        for (int k = 0; k < 10; k++) sclk_cycle(d1[W-1-k], 1'b1, "R3 local bit");
        // R7: deselect mid-word
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sdo_oe == 1'b0, "R7 oe off when deselected", sdo_oe, 0);
        for (int k = 0; k < 3; k++) sclk_cycle(1'b1, 1'b0, "R7");
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 10; k < W - 1; k++) sclk_cycle(d1[W-1-k], 1'b1, "R3 local bit");
        sclk_cycle(d1[0], 1'b1, "R3 last local bit");
        for (int k = 0; k < W; k++) sclk_cycle(1'b0, 1'b1, "R5 forwarded sdi bit");
        for (int k = 0; k < 4; k++) sclk_cycle(1'b0, 1'b1, "R6 zero fill");

        // R8: partial read, then new capture
        strobe(w2, 1'b1, "R8 capture");
        exp_q.delete();
        push_word(w2, W - 1);
        for (int k = 0; k < 5; k++) sclk_cycle(1'b0, 1'b1, "R8 partial read");
        strobe(w3, 1'b1, "R8 recapture over partial read");
        exp_q.delete();
        push_word(w3, W - 1);
        for (int k = 0; k < 3; k++) sclk_cycle(1'b0, 1'b1, "R8 new word bit");

        // R9: sync mid-frame restarts the window
        do_sync();
        for (int i = 0; i < SP; i++) strobe(24'hFFFFFF, 1'b0, "R9 window restart");
        strobe(w4, 1'b1, "R9 capture after window");
        exp_q.delete();
        push_word(w4, W - 1);
        for (int k = 0; k < 4; k++) sclk_cycle(1'b0, 1'b1, "R3 after resync");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule